// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block models the control and address path of a pipelined synchronous burst SRAM around a small on-chip array. All inputs are captured on the rising clock edge. Either of two address strobes starts a four-beat burst at the presented address. The strobe on the processor side always reads. The strobe on the cache-controller side reads or writes, as the write enables say. Later beats take their addresses from an internal 2-bit beat counter. The counter moves only on cycles with the advance input high, and the beat order is linear or interleaved. Read data passes through an output register.

The shared data bus is split into a `din` input, a `dout` output and a `dout_en` drive flag. A write can touch any subset of the 9-bit byte lanes, and a global write input forces every lane. A strobe that arrives while the chip is not selected is a deselect. It ends the burst and lets the drive flag fall after either one or two cycles. The bus is a plain synchronous SRAM port, so it has no handshake and no back-pressure.

Top module: `sbsram_core`

## Requirements
- R1: After reset, `dout` is zero and `dout_en` is low, and no location is accessed until a strobe with the chip selected starts a burst.
- R2: A cycle with `start_cpu` high and the chip selected (`sel_a` and `sel_b` high, `sel_n` low) starts a read burst at `addr`, even when `start_ctl`, `wr_all` or `wr_lane` are also asserted. No lane is written.
- R3: A cycle with `start_ctl` high, `start_cpu` low and the chip selected starts a burst at `addr`. That first beat is a write when `wr_all` or any `wr_lane` bit is high, and a read otherwise.
- R4: With `order_sel` low when the burst started, beat k (k = 0..3, k counts advance cycles modulo 4) accesses the address whose upper bits equal `addr[AW-1:2]` and whose two low bits are (s + k) mod 4, where s is `addr[1:0]` at the start.
- R5: With `order_sel` high when the burst started, the two low bits of beat k are s XOR k. Only the value of `order_sel` at the burst start matters.
- R6: During a burst, a cycle with no strobe and `advance` low accesses the same location again. The beat is a write if any write enable is high and a read otherwise. `advance` high moves to the next beat with the same direction rule.
- R7: A write updates lane i (bits 9i+8 down to 9i of `din`) only when `wr_lane[i]` or `wr_all` is high. All other lanes keep their contents.
- R8: Read data for a beat appears on `dout` two rising edges after the beat's inputs are presented: one edge for the input register and one for the output register. `dout` holds its value until the next read.
- R9: `dout_en` equals `oe` ANDed with a drive flag. The flag is high for the cycle after a read access, and it stays low after write and idle cycles.
- R10: A strobe while the chip is not selected ends the burst without access. With `two_cycle_deselect` low, the drive flag drops right after. With it high, the flag stays high for one more cycle if a read had just completed.
- R11: With no burst active, `advance` and the write enables have no effect: nothing is written, and `dout_en` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | Burst start address |
| start_cpu | input | 1 | Processor-side burst strobe (read) |
| start_ctl | input | 1 | Controller-side burst strobe |
| advance | input | 1 | Step the beat counter |
| sel_a | input | 1 | Chip select, active high |
| sel_b | input | 1 | Chip select, active high |
| sel_n | input | 1 | Chip select, active low |
| wr_all | input | 1 | Write every lane |
| wr_lane | input | LANES | Per-lane write enables |
| order_sel | input | 1 | 0 linear, 1 interleaved burst order |
| two_cycle_deselect | input | 1 | 1 keeps outputs driven one extra cycle after deselect |
| oe | input | 1 | Output enable |
| din | input | LANES*LW | Write data |
| dout | output | LANES*LW | Registered read data |
| dout_en | output | 1 | Data bus drive flag |

## Verification
Inputs presented before edge n become a beat at edge n+1. For a read, that beat's data and the raised drive flag show at edge n+1, two edges after the inputs. A deselect's one-cycle drive tail shows at edge n+1 as well, and `oe` gates the flag with no delay. The bench drives one beat per cycle at the falling edge. It keeps a three-deep record of expected beats and compares `dout` and `dout_en` at every falling edge against the beat issued two cycles earlier. The drive tail also uses the beat issued three cycles earlier.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_DSEL,
    OP_START,
    OP_ADV,
    OP_HOLD
  } op_e;

  function automatic logic [1:0] beat_offset(logic [1:0] start, logic [1:0] beat, logic interleave);
    return interleave ? (start ^ beat) : (start + beat);
  endfunction

endpackage

// File: rtl/sbsram_inreg.sv
module sbsram_inreg #(
  parameter int AW    = 6,
  parameter int LANES = 4,
  parameter int LW    = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [AW-1:0]         addr,
  input  logic                  start_cpu,
  input  logic                  start_ctl,
  input  logic                  advance,
  input  logic                  sel_a,
  input  logic                  sel_b,
  input  logic                  sel_n,
  input  logic                  wr_all,
  input  logic [LANES-1:0]      wr_lane,
  input  logic                  order_sel,
  input  logic                  two_cycle_deselect,
  input  logic [LANES*LW-1:0]   din,
  output logic [AW-1:0]         q_addr,
  output logic                  q_cpu,
  output logic                  q_ctl,
  output logic                  q_adv,
  output logic                  q_sel,
  output logic                  q_wr_any,
  output logic                  q_order,
  output logic                  q_two,
  output logic [LANES-1:0]      q_lane_en,
  output logic [LANES*LW-1:0]   q_din
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_addr    <= '0;
      q_cpu     <= 1'b0;
      q_ctl     <= 1'b0;
      q_adv     <= 1'b0;
      q_sel     <= 1'b0;
      q_wr_any  <= 1'b0;
      q_order   <= 1'b0;
      q_two     <= 1'b0;
      q_lane_en <= '0;
      q_din     <= '0;
    end else begin
      q_addr    <= addr;
      q_cpu     <= start_cpu;
      q_ctl     <= start_ctl;
      q_adv     <= advance;
      q_sel     <= sel_a & sel_b & ~sel_n;
      q_wr_any  <= wr_all | (|wr_lane);
      q_order   <= order_sel;
      q_two     <= two_cycle_deselect;
      q_lane_en <= wr_all ? {LANES{1'b1}} : wr_lane;
      q_din     <= din;
    end
  end

endmodule

// File: rtl/sbsram_burst.sv
module sbsram_burst
  import sbsram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] q_addr,
  input  logic          q_cpu,
  input  logic          q_ctl,
  input  logic          q_adv,
  input  logic          q_sel,
  input  logic          q_wr_any,
  input  logic          q_order,
  output op_e           op,
  output logic          acc_rd,
  output logic          acc_wr,
  output logic [AW-1:0] acc_addr,
  output logic [1:0]    beat_q
);

  logic          act_q, act_n;
  logic          ord_q, ord_n;
  logic [AW-1:0] base_q, base_n;
  logic [1:0]    beat_n;
  logic          acc_on;

  always_comb begin
    op = OP_IDLE;
    if (q_cpu || q_ctl) begin
      op = q_sel ? OP_START : OP_DSEL;
    end else if (act_q) begin
      op = q_adv ? OP_ADV : OP_HOLD;
    end
  end

  always_comb begin
    beat_n = beat_q;
    base_n = base_q;
    ord_n  = ord_q;
    act_n  = act_q;
    case (op)
      OP_START: begin
        beat_n = 2'd0;
        base_n = q_addr;
        ord_n  = q_order;
        act_n  = 1'b1;
      end
      OP_DSEL: act_n  = 1'b0;
      OP_ADV:  beat_n = beat_q + 2'd1;
      default: ;
    endcase
  end

  always_comb begin
    acc_on   = (op == OP_START) || (op == OP_ADV) || (op == OP_HOLD);
    acc_wr   = acc_on && q_wr_any && !((op == OP_START) && q_cpu);
    acc_rd   = acc_on && !acc_wr;
    acc_addr = {base_n[AW-1:2], beat_offset(base_n[1:0], beat_n, ord_n)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      ord_q  <= 1'b0;
      base_q <= '0;
      beat_q <= 2'd0;
    end else begin
      act_q  <= act_n;
      ord_q  <= ord_n;
      base_q <= base_n;
      beat_q <= beat_n;
    end
  end

endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
  parameter int AW    = 6,
  parameter int LANES = 4,
  parameter int LW    = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_rd,
  input  logic                acc_wr,
  input  logic [AW-1:0]       acc_addr,
  input  logic [LANES-1:0]    lane_en,
  input  logic [LANES*LW-1:0] wdata,
  output logic [LANES*LW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];
    logic [LW-1:0] out_q;

    always_ff @(posedge clk) begin
      if (acc_wr && lane_en[g]) mem[acc_addr] <= wdata[g*LW +: LW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      out_q <= '0;
      else if (acc_rd) out_q <= mem[acc_addr];
    end

    assign rdata[g*LW +: LW] = out_q;
  end

endmodule

// File: rtl/sbsram_core.sv
module sbsram_core
  import sbsram_pkg::*;
#(
  parameter int AW    = 6,
  parameter int LANES = 4,
  parameter int LW    = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AW-1:0]       addr,
  input  logic                start_cpu,
  input  logic                start_ctl,
  input  logic                advance,
  input  logic                sel_a,
  input  logic                sel_b,
  input  logic                sel_n,
  input  logic                wr_all,
  input  logic [LANES-1:0]    wr_lane,
  input  logic                order_sel,
  input  logic                two_cycle_deselect,
  input  logic                oe,
  input  logic [LANES*LW-1:0] din,
  output logic [LANES*LW-1:0] dout,
  output logic                dout_en
);

  localparam int DW = LANES * LW;

  logic [AW-1:0]    q_addr;
  logic             q_cpu, q_ctl, q_adv, q_sel, q_wr_any, q_order, q_two;
  logic [LANES-1:0] q_lane_en;
  logic [DW-1:0]    q_din;
  op_e              op;
  logic             acc_rd, acc_wr;
  logic [AW-1:0]    acc_addr;
  logic [1:0]       beat_q;
  logic             rd_q, tail_q;

  sbsram_inreg #(.AW(AW), .LANES(LANES), .LW(LW)) u_inreg (
    .clk(clk), .rst_n(rst_n), .addr(addr), .start_cpu(start_cpu),
    .start_ctl(start_ctl), .advance(advance), .sel_a(sel_a), .sel_b(sel_b),
    .sel_n(sel_n), .wr_all(wr_all), .wr_lane(wr_lane), .order_sel(order_sel),
    .two_cycle_deselect(two_cycle_deselect), .din(din),
    .q_addr(q_addr), .q_cpu(q_cpu), .q_ctl(q_ctl), .q_adv(q_adv), .q_sel(q_sel),
    .q_wr_any(q_wr_any), .q_order(q_order), .q_two(q_two),
    .q_lane_en(q_lane_en), .q_din(q_din)
  );

  sbsram_burst #(.AW(AW)) u_burst (
    .clk(clk), .rst_n(rst_n), .q_addr(q_addr), .q_cpu(q_cpu), .q_ctl(q_ctl),
    .q_adv(q_adv), .q_sel(q_sel), .q_wr_any(q_wr_any), .q_order(q_order),
    .op(op), .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_addr(acc_addr),
    .beat_q(beat_q)
  );

  sbsram_array #(.AW(AW), .LANES(LANES), .LW(LW)) u_array (
    .clk(clk), .rst_n(rst_n), .acc_rd(acc_rd), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .lane_en(q_lane_en), .wdata(q_din), .rdata(dout)
  );

  // Output drive pipeline: one flag per completed read, plus a one-cycle tail on deselect.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      tail_q <= 1'b0;
    end else begin
      rd_q   <= acc_rd;
      tail_q <= q_two && (op == OP_DSEL) && rd_q;
    end
  end

  assign dout_en = oe & (rd_q | tail_q);

endmodule

// File: rtl/sbsram_core_chk.sv
module sbsram_core_chk
  import sbsram_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input op_e        op,
  input logic       q_cpu,
  input logic [1:0] beat_q,
  input logic       rd_q,
  input logic       q_two,
  input logic       oe,
  input logic       dout_en
);

  // R6
  hold_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_HOLD) |=> $stable(beat_q));

  // R4
  adv_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ADV) |=> (beat_q == $past(beat_q) + 2'd1));

  // R2
  cpu_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_START && q_cpu) |=> (rd_q && beat_q == 2'd0));

  // R9
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> !dout_en);

  // R10
  dsel_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_DSEL && !q_two) |=> !dout_en);

  // R10
  dsel_dual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_DSEL && q_two && rd_q) |=> (dout_en || !oe));

endmodule

bind sbsram_core sbsram_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op(op), .q_cpu(q_cpu), .beat_q(beat_q),
  .rd_q(rd_q), .q_two(q_two), .oe(oe), .dout_en(dout_en)
);

// File: tb/sbsram_core_test.sv
module sbsram_core_test;

  localparam int AW    = 6;
  localparam int LANES = 4;
  localparam int LW    = 9;
  localparam int DW    = LANES * LW;
  localparam int DEPTH = 1 << AW;

  logic clk, rst_n;
  logic [AW-1:0] addr;
  logic start_cpu, start_ctl, advance, sel_a, sel_b, sel_n, wr_all;
  logic [LANES-1:0] wr_lane;
  logic order_sel, two_cycle_deselect, oe;
  logic [DW-1:0] din, dout;
  logic dout_en;

  sbsram_core #(.AW(AW), .LANES(LANES), .LW(LW)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .start_cpu(start_cpu),
    .start_ctl(start_ctl), .advance(advance), .sel_a(sel_a), .sel_b(sel_b),
    .sel_n(sel_n), .wr_all(wr_all), .wr_lane(wr_lane), .order_sel(order_sel),
    .two_cycle_deselect(two_cycle_deselect), .oe(oe), .din(din),
    .dout(dout), .dout_en(dout_en)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [DW-1:0] ref_mem [DEPTH];
  bit            m_act = 1'b0;
  bit            m_ord = 1'b0;
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_cnt = 2'd0;

  bit p1_rd = 0, p2_rd = 0, p3_rd = 0;
  bit p1_dsel = 0, p2_dsel = 0;
  bit p1_dual = 0, p2_dual = 0;
  bit p1_idle = 0, p2_idle = 0;
  logic [DW-1:0] p1_data = '0, p2_data = '0;
  string p1_tag = "R8", p2_tag = "R8";
  string tag_override = "";
  bit cur_oe = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input bit cpu, input bit ctl, input bit adv,
                      input bit sa, input bit sb, input bit sn,
                      input bit wall, input logic [LANES-1:0] wl,
                      input logic [DW-1:0] d, input bit ord, input bit dual,
                      input bit oe_i, input logic [AW-1:0] a);
    bit exp_en, sel, wr, acc, wr_op, c_rd, c_dsel, c_idle;
    logic [1:0] off;
    logic [AW-1:0] ad;
    logic [DW-1:0] c_data;
    string c_tag;
    @(negedge clk);
    exp_en = cur_oe && (p2_rd || (p2_dual && p2_dsel && p3_rd));
    check(dout_en == exp_en, p2_dsel ? "R10" : (p2_idle ? "R11" : "R9"),
          {{(DW-1){1'b0}}, dout_en}, {{(DW-1){1'b0}}, exp_en});
    if (p2_rd) check(dout == p2_data, p2_tag, dout, p2_data);

    start_cpu = cpu; start_ctl = ctl; advance = adv;
    sel_a = sa; sel_b = sb; sel_n = sn;
    wr_all = wall; wr_lane = wl; din = d; order_sel = ord;
    two_cycle_deselect = dual; oe = oe_i; addr = a;
    cur_oe = oe_i;

    sel = sa && sb && !sn;
    wr = wall || (|wl);
    acc = 0; wr_op = 0; c_rd = 0; c_dsel = 0; c_idle = 0; c_data = '0; c_tag = "R8";
    if (cpu || ctl) begin
      if (sel) begin
        m_base = a; m_cnt = 2'd0; m_ord = ord; m_act = 1'b1;
        acc = 1; wr_op = wr && !cpu;
        c_tag = cpu ? "R2" : "R3";
      end else begin
        m_act = 1'b0; c_dsel = 1;
      end
    end else if (!m_act) begin
      c_idle = 1;
    end else if (adv) begin
      m_cnt = m_cnt + 2'd1;
      acc = 1; wr_op = wr;
      c_tag = m_ord ? "R5" : "R4";
    end else begin
      acc = 1; wr_op = wr; c_tag = "R6";
    end
    if (acc) begin
      off = m_ord ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
      ad = {m_base[AW-1:2], off};
      if (wr_op) begin
        for (int i = 0; i < LANES; i++)
          if (wall || wl[i]) ref_mem[ad][i*LW +: LW] = d[i*LW +: LW];
      end else begin
        c_rd = 1; c_data = ref_mem[ad];
      end
    end
    if (tag_override != "") c_tag = tag_override;

    p3_rd = p2_rd;
    p2_rd = p1_rd; p2_dsel = p1_dsel; p2_dual = p1_dual; p2_idle = p1_idle;
    p2_data = p1_data; p2_tag = p1_tag;
    p1_rd = c_rd; p1_dsel = c_dsel; p1_dual = dual; p1_idle = c_idle;
    p1_data = c_data; p1_tag = c_tag;
  endtask

  task automatic idle_steps(input int n, input bit dual);
    for (int i = 0; i < n; i++) step(0, 0, 0, 1, 1, 0, 0, '0, '0, 0, dual, 1, '0);
  endtask

  function automatic logic [31:0] xs(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0;
    addr = '0; start_cpu = 0; start_ctl = 0; advance = 0;
    sel_a = 0; sel_b = 0; sel_n = 1; wr_all = 0; wr_lane = '0;
    order_sel = 0; two_cycle_deselect = 0; oe = 0; din = '0;
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(dout_en == 1'b0, "R1", {{(DW-1){1'b0}}, dout_en}, '0);
    check(dout == '0, "R1", dout, '0);
    // R1 / R11: no burst active, advance and writes ignored
    for (int i = 0; i < 4; i++) step(0, 0, 1, 1, 1, 0, 1, 4'hF, 36'hABCDE1234, 0, 0, 1, 6'd3);

    // Preload with controller-started write bursts, all lanes (R3, R4, R7)
    for (int b = 0; b < DEPTH; b += 4) begin
      step(0, 1, 0, 1, 1, 0, 1, '0, {4'h5, 26'(b * 7919), 6'(b)}, 0, 0, 1, AW'(b));
      for (int k = 1; k < 4; k++)
        step(0, 0, 1, 1, 1, 0, 1, '0, {4'hA, 26'((b + k) * 104729), 6'(b + k)}, 0, 0, 1, '0);
    end

    // Read sweep: every start offset, both orders; processor strobe ignores write enables (R2, R4, R5)
    for (int o = 0; o < 2; o++)
      for (int s = 0; s < 4; s++)
        for (int blk = 0; blk < 16; blk += 5) begin
          step(1, 1, 0, 1, 1, 0, 1, 4'hF, '1, o[0], 0, 1, {4'(blk), 2'(s)});
          for (int k = 1; k < 4; k++) step(0, 0, 1, 1, 1, 0, 0, '0, '0, 0, 0, 1, '0);
          step(0, 0, 1, 1, 1, 0, 0, '0, '0, 0, 0, 1, '0);  // wraps to beat 0
        end

    // Byte-lane merge (R7)
    tag_override = "R7";
    step(0, 1, 0, 1, 1, 0, 0, 4'b0101, '1, 0, 0, 1, 6'd9);
    step(0, 0, 0, 1, 1, 0, 0, 4'b1000, 36'h123456789, 0, 0, 1, '0);
    step(0, 1, 0, 1, 1, 0, 0, '0, '0, 0, 0, 1, 6'd9);
    step(0, 0, 0, 1, 1, 0, 0, '0, '0, 0, 0, 1, '0);
    tag_override = "R8";
    step(1, 0, 0, 1, 1, 0, 0, '0, '0, 1, 0, 1, 6'd22);
    idle_steps(3, 0);
    tag_override = "";

    // Deselect, single and dual (R10), then advance while idle (R11)
    for (int dl = 0; dl < 2; dl++) begin
      step(0, 1, 0, 1, 1, 0, 0, '0, '0, 0, dl[0], 1, 6'd40);
      step(0, 0, 1, 1, 1, 0, 0, '0, '0, 0, dl[0], 1, '0);
      step(1, 0, 0, 1, 1, 1, 0, '0, '0, 0, dl[0], 1, 6'd0);
      for (int i = 0; i < 3; i++) step(0, 0, 1, 1, 1, 0, 1, 4'hF, '1, 0, dl[0], 1, '0);
      step(0, 1, 0, 0, 1, 0, 0, '0, '0, 0, dl[0], 1, 6'd41);
      idle_steps(3, dl[0]);
      step(1, 0, 0, 1, 1, 0, 0, '0, '0, 0, dl[0], 1, 6'd40);
      idle_steps(3, dl[0]);
    end

    // Mixed pseudo-random traffic: holds, advances, partial writes, oe low (R6, R9)
    r = 32'h1234_5678;
    for (int n = 0; n < 4000; n++) begin
      r = xs(r);
      step(&r[2:0], &r[5:3], r[6], !(&r[9:7]), 1'b1, &r[12:10],
           &r[14:13], r[18:15] & {4{r[19]}}, {r, r[23:20]}, r[24],
           (n >= 2000), !(&r[27:25]), r[31:26]);
    end
    idle_steps(4, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule